// File: doc/BRIEF.md
# Palette Lookup and Pixel Unpacker

This block sits between a pixel FIFO and the output stage of a raster display pipeline. It takes packed data words from the FIFO and produces one 16-bit RGB565 colour for each pixel-clock enable. At the start of every frame it first captures a palette from the leading words of the stream. It then splits each following word into pixels of 1, 2, 4, 8 or 16 bits.

Low bit depths index the palette. Each palette entry holds a 12-bit 4:4:4 colour, which the block widens to 565. At 12 and 16 bits per pixel the halfwords pass straight through as RGB565. A greyscale mode reads only the blue nibble of the palette entry. A raw 8-bit grey sub-mode bypasses the palette altogether.

The FIFO interface is a valid/ready handshake. A start-of-frame flag rides on the first word of each frame. The depth, order and grey controls are sampled together with that first word and held until the next one.

Top module: `pal_unpack`

## Requirements
- R1: After reset, pix_valid is 0, pix_rgb is 0 and fifo_ready is 1.
- R2: Words accepted before the first word flagged with fifo_sof are discarded, and no pixel is produced from them.
- R3: The sof word and the words after it fill the palette before any pixel is produced. Each 32-bit word holds two 16-bit entries, with the even entry in bits 15:0. Colour 8 bpp (depth code 3, grey off) loads 256 entries in 128 words; every other mode loads 16 entries in 8 words. During the load fifo_ready stays 1 and every pix_en edge gives pix_valid 0.
- R4: In colour 8 bpp, each 8-bit pixel indexes the palette. An entry holds red in bits 11:8, green in bits 7:4 and blue in bits 3:0. The output is {r,r[3]} in 15:11, {g,g[3:2]} in 10:5 and {b,b[3]} in 4:0.
- R5: Depth codes 4 (12 bpp), 5 (16 bpp) and above take 16-bit pixels and output them unchanged as RGB565 (red 15:11, green 10:5, blue 4:0), without reading the palette. The 0x4000 format marker in entry 0 does not affect them.
- R6: Depth codes 0, 1 and 2 take 1-, 2- and 4-bit indices into entries 0 to 15, with the same widening as R4.
- R7: With order_sel 0, pixels are taken starting at bit 0 of the word; with order_sel 1, starting at the most significant bit.
- R8: With mono_en set and mono8_en clear, at depth codes 0 to 3, the low 4 bits of the pixel index the palette. The grey level g is bits 3:0 of the entry, and the output is {g,g[3]}, {g,g[3:2]}, {g,g[3]}.
- R9: With mono_en and mono8_en both set, each 8-bit pixel v is a grey value and the output is {v[7:3], v[7:2], v[7:3]}. Sixteen palette entries are still loaded.
- R10: pix_rgb and pix_valid change only at an edge where pix_en is 1. Each such edge consumes exactly one pixel. If no pixel is waiting, pix_valid goes to 0 and pix_rgb holds.
- R11: A sof word that arrives after the pixels of a frame restarts the palette load, and the next pixels use the new palette.
- R12: bpp_sel, order_sel, mono_en and mono8_en are sampled only when a sof word is accepted. Later changes have no effect until the next sof word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | WORD_W | Packed word from the pixel FIFO |
| fifo_valid | input | 1 | fifo_data holds a word |
| fifo_sof | input | 1 | Word is the first of a frame |
| fifo_ready | output | 1 | Block takes the word at this edge |
| bpp_sel | input | 3 | Depth code: 0=1, 1=2, 2=4, 3=8, 4=12, 5=16 bits |
| order_sel | input | 1 | 0 low bits first, 1 high bits first |
| mono_en | input | 1 | Greyscale output |
| mono8_en | input | 1 | Raw 8-bit grey pixels (with mono_en) |
| pix_en | input | 1 | Pixel-clock enable |
| pix_rgb | output | 16 | RGB565 colour of the last pixel |
| pix_valid | output | 1 | pix_rgb holds a pixel from the last enable |

## Verification
The bench uses the default parameters: 32-bit words and a 256-entry palette. With these values a word holds two palette entries, so a load takes 8 or 128 words. A word also holds anywhere from 32 one-bit pixels down to two direct halfwords. This puts both palette sizes within reach, as well as the last-slot hand-over between words and the high-order indices that exist only in the 256-entry load. The palette pattern gives every entry a distinct red nibble and an inverted blue nibble, so a wrong index, a wrong order or a wrong channel shows up in the output value.

// File: rtl/pal_unpack_pkg.sv
package pal_unpack_pkg;

  localparam logic [2:0] DEPTH_8  = 3'd3;
  localparam logic [2:0] DEPTH_12 = 3'd4;

  typedef struct packed {
    logic [2:0] depth;
    logic       msb_first;
    logic       mono;
    logic       mono8;
  } pu_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PIX} pu_state_e;

  // log2 of the pixel width in bits
  function automatic logic [2:0] pix_log2(pu_cfg_t c);
    if (c.mono && c.mono8) return 3'd3;
    case (c.depth)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic is_direct(pu_cfg_t c);
    return !(c.mono && c.mono8) && (c.depth >= DEPTH_12);
  endfunction

  function automatic logic wide_palette(pu_cfg_t c);
    return (c.depth == DEPTH_8) && !c.mono;
  endfunction

  function automatic logic [15:0] widen444(logic [11:0] e);
    return {e[11:8], e[11], e[7:4], e[7:6], e[3:0], e[3]};
  endfunction

  function automatic logic [15:0] grey4(logic [3:0] g);
    return {g, g[3], g, g[3:2], g, g[3]};
  endfunction

  function automatic logic [15:0] grey8(logic [7:0] v);
    return {v[7:3], v[7:2], v[7:3]};
  endfunction

endpackage

// File: rtl/pu_palette.sv
module pu_palette #(
  parameter int WORD_W    = 32,
  parameter int PAL_DEPTH = 256,
  localparam int LANES    = WORD_W / 16,
  localparam int IDX_W    = $clog2(PAL_DEPTH),
  localparam int WI_W     = $clog2(PAL_DEPTH / LANES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WI_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       rd_data
);

  logic [15:0] mem [PAL_DEPTH];

  // one word fills LANES consecutive entries, lowest halfword first
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int g = 0; g < LANES; g++) begin
        mem[IDX_W'(int'(wr_idx) * LANES + g)] <= wr_data[16*g +: 16];
      end
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/pu_unpack.sv
module pu_unpack
  import pal_unpack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  input  pu_cfg_t           cfg,
  output logic [15:0]       raw,
  output logic              word_vld,
  output logic              last_slot
);

  localparam int SLOT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;

  function automatic logic [15:0] grab(logic [WORD_W-1:0] w, logic [2:0] lg,
                                       logic [SLOT_W-1:0] slot, logic msb);
    int                off;
    logic [WORD_W-1:0] sh;
    logic [15:0]       mask;
    off  = msb ? (WORD_W - ((int'(slot) + 1) << lg)) : (int'(slot) << lg);
    sh   = w >> off;
    mask = 16'((32'd1 << (32'd1 << lg)) - 32'd1);
    return sh[15:0] & mask;
  endfunction

  assign raw       = grab(word_q, pix_log2(cfg), slot_q, cfg.msb_first);
  assign last_slot = (int'(slot_q) == (WORD_W >> pix_log2(cfg)) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      slot_q   <= '0;
      word_vld <= 1'b0;
    end else if (load) begin
      word_q   <= load_word;
      slot_q   <= '0;
      word_vld <= 1'b1;
    end else if (advance) begin
      if (last_slot) word_vld <= 1'b0;
      else           slot_q   <= slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/pu_colour.sv
module pu_colour
  import pal_unpack_pkg::*;
(
  input  pu_cfg_t     cfg,
  input  logic [15:0] raw,
  input  logic [15:0] pal_entry,
  output logic [15:0] rgb
);

  always_comb begin
    if (is_direct(cfg))            rgb = raw;
    else if (cfg.mono && cfg.mono8) rgb = grey8(raw[7:0]);
    else if (cfg.mono)             rgb = grey4(pal_entry[3:0]);
    else                           rgb = widen444(pal_entry[11:0]);
  end

endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
  import pal_unpack_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PAL_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_valid,
  input  logic              fifo_sof,
  output logic              fifo_ready,
  input  logic [2:0]        bpp_sel,
  input  logic              order_sel,
  input  logic              mono_en,
  input  logic              mono8_en,
  input  logic              pix_en,
  output logic [15:0]       pix_rgb,
  output logic              pix_valid
);

  localparam int LANES       = WORD_W / 16;
  localparam int IDX_W       = $clog2(PAL_DEPTH);
  localparam int WI_W        = $clog2(PAL_DEPTH / LANES);
  localparam int WORDS_WIDE  = PAL_DEPTH / LANES;
  localparam int WORDS_SMALL = 16 / LANES;

  pu_state_e   state_q;
  pu_cfg_t     cfg_q, cfg_in, cfg_now;
  logic [WI_W-1:0] widx_q, pal_widx, pal_last;

  // named events
  logic accept, sof_take, pal_we, pix_load, advance, underrun;
  logic in_idle, in_load, in_pix;
  logic word_vld, last_slot;
  logic [15:0] raw, pal_entry, colour;
  logic [IDX_W-1:0] pal_ridx;

  assign cfg_in   = '{depth: bpp_sel, msb_first: order_sel, mono: mono_en, mono8: mono8_en};
  assign in_idle  = (state_q == ST_IDLE);
  assign in_load  = (state_q == ST_LOAD);
  assign in_pix   = (state_q == ST_PIX);

  assign fifo_ready = !in_pix || !word_vld || (pix_en && last_slot);
  assign accept     = fifo_valid && fifo_ready;
  assign sof_take   = accept && fifo_sof;
  assign cfg_now    = sof_take ? cfg_in : cfg_q;
  assign pal_last   = wide_palette(cfg_now) ? WI_W'(WORDS_WIDE - 1) : WI_W'(WORDS_SMALL - 1);
  assign pal_we     = sof_take || (accept && in_load);
  assign pal_widx   = sof_take ? '0 : widx_q;
  assign pix_load   = accept && !fifo_sof && in_pix;
  assign advance    = pix_en && word_vld && in_pix;
  assign underrun   = pix_en && !(word_vld && in_pix);

  // grey modes only ever look at the first sixteen entries
  assign pal_ridx = cfg_q.mono ? IDX_W'(raw[3:0]) : raw[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      widx_q  <= '0;
    end else if (sof_take) begin
      cfg_q   <= cfg_in;
      widx_q  <= WI_W'(1);
      state_q <= ST_LOAD;
    end else if (accept && in_load) begin
      widx_q <= widx_q + 1'b1;
      if (widx_q == pal_last) state_q <= ST_PIX;
    end
  end

  pu_palette #(.WORD_W(WORD_W), .PAL_DEPTH(PAL_DEPTH)) u_pal (
    .clk     (clk),
    .wr_en   (pal_we),
    .wr_idx  (pal_widx),
    .wr_data (fifo_data),
    .rd_idx  (pal_ridx),
    .rd_data (pal_entry)
  );

  pu_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pix_load),
    .load_word (fifo_data),
    .advance   (advance),
    .cfg       (cfg_q),
    .raw       (raw),
    .word_vld  (word_vld),
    .last_slot (last_slot)
  );

  pu_colour u_colour (
    .cfg       (cfg_q),
    .raw       (raw),
    .pal_entry (pal_entry),
    .rgb       (colour)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_rgb   <= '0;
    end else if (pix_en) begin
      pix_valid <= advance;
      if (advance) pix_rgb <= colour;
    end
  end

endmodule

// File: rtl/pal_unpack_chk.sv
module pal_unpack_chk
  import pal_unpack_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        pix_en,
  input logic        pix_valid,
  input logic [15:0] pix_rgb,
  input logic        fifo_ready,
  input logic        in_idle,
  input logic        in_load,
  input logic        underrun,
  input logic        advance,
  input logic        word_vld,
  input logic        sof_take,
  input logic [15:0] raw,
  input pu_cfg_t     cfg
);

  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_rgb) && $stable(pix_valid)); // R10

  AST_UNDERRUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !pix_valid); // R10

  AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_load && pix_en |=> !pix_valid); // R3

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |-> fifo_ready); // R3

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !word_vld); // R2

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    advance && is_direct(cfg) |=> pix_rgb == $past(raw)); // R5

  AST_GREY8_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    advance && cfg.mono && cfg.mono8 |=> pix_rgb[15:11] == pix_rgb[4:0]); // R9

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_take |=> $stable(cfg)); // R12

endmodule

bind pal_unpack pal_unpack_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .pix_valid  (pix_valid),
  .pix_rgb    (pix_rgb),
  .fifo_ready (fifo_ready),
  .in_idle    (in_idle),
  .in_load    (in_load),
  .underrun   (underrun),
  .advance    (advance),
  .word_vld   (word_vld),
  .sof_take   (sof_take),
  .raw        (raw),
  .cfg        (cfg_q)
);

// File: tb/pal_unpack_tb_top.sv
module pal_unpack_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] fifo_data = '0;
  logic              fifo_valid = 1'b0;
  logic              fifo_sof = 1'b0;
  logic              fifo_ready;
  logic [2:0]        bpp_sel = '0;
  logic              order_sel = 1'b0;
  logic              mono_en = 1'b0;
  logic              mono8_en = 1'b0;
  logic              pix_en = 1'b0;
  logic [15:0]       pix_rgb;
  logic              pix_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_unpack #(.WORD_W(WORD_W), .PAL_DEPTH(256)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_data  (fifo_data),
    .fifo_valid (fifo_valid),
    .fifo_sof   (fifo_sof),
    .fifo_ready (fifo_ready),
    .bpp_sel    (bpp_sel),
    .order_sel  (order_sel),
    .mono_en    (mono_en),
    .mono8_en   (mono8_en),
    .pix_en     (pix_en),
    .pix_rgb    (pix_rgb),
    .pix_valid  (pix_valid)
  );

  typedef struct packed {
    logic [2:0]  bpp;
    logic        ord;
    logic        mono;
    logic        m8;
    logic [31:0] word;
    logic [4:0]  slot;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // palette used: entry i = {0, i[3:0]^key, i[7:4], ~i[3:0]}
  localparam vec_t VECS [11] = '{
    '{3'd3, 1'b0, 1'b0, 1'b0, 32'h44332211, 5'd0, 16'h109D, 4'd4}, // R4 entry 0x11
    '{3'd3, 1'b1, 1'b0, 1'b0, 32'h80332211, 5'd0, 16'h045F, 4'd4}, // R4 R3 entry 0x80
    '{3'd2, 1'b0, 1'b0, 1'b0, 32'h000000C0, 5'd1, 16'hC806, 4'd6}, // R6 4-bit
    '{3'd2, 1'b1, 1'b0, 1'b0, 32'h70000000, 5'd0, 16'h7011, 4'd7}, // R7 high first
    '{3'd0, 1'b0, 1'b0, 1'b0, 32'h00000004, 5'd2, 16'h101D, 4'd6}, // R6 1-bit
    '{3'd1, 1'b1, 1'b0, 1'b0, 32'h20000000, 5'd1, 16'h201B, 4'd7}, // R7 2-bit
    '{3'd5, 1'b0, 1'b0, 1'b0, 32'hBEEF1234, 5'd1, 16'hBEEF, 4'd5}, // R5 16 bpp
    '{3'd4, 1'b1, 1'b0, 1'b0, 32'hBEEF1234, 5'd1, 16'h1234, 4'd5}, // R5 12 bpp
    '{3'd2, 1'b0, 1'b1, 1'b0, 32'h00000009, 5'd0, 16'h632C, 4'd8}, // R8 grey
    '{3'd3, 1'b0, 1'b1, 1'b1, 32'h0000B700, 5'd1, 16'hB5B6, 4'd9}, // R9 raw grey
    '{3'd3, 1'b1, 1'b1, 1'b1, 32'hC3000000, 5'd0, 16'hC618, 4'd9}  // R9 raw grey
  };

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pal_of(input int i, input logic [3:0] key, input logic [2:0] bpp);
    logic [7:0] b;
    b = 8'(i);
    if (bpp >= 3'd4 && i == 0) return 16'h4000;
    return {4'h0, b[3:0] ^ key, b[7:4], ~b[3:0]};
  endfunction

  task automatic push(input logic [31:0] w, input logic sof);
    @(negedge clk);
    fifo_data  = w;
    fifo_sof   = sof;
    fifo_valid = 1'b1;
    #1;
    while (!fifo_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    fifo_valid = 1'b0;
    fifo_sof   = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic pal_word(input int w, input logic [3:0] key, input logic [2:0] bpp);
    push({pal_of(2*w+1, key, bpp), pal_of(2*w, key, bpp)}, w == 0);
  endtask

  task automatic start_frame(input logic [2:0] bpp, input logic ord, input logic mono,
                             input logic m8, input logic [3:0] key);
    int n;
    bpp_sel   = bpp;
    order_sel = ord;
    mono_en   = mono;
    mono8_en  = m8;
    n = (bpp == 3'd3 && !mono) ? 256 : 16;
    for (int w = 0; w < n/2; w++) pal_word(w, key, bpp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check16("R1 pix_valid", 16'(pix_valid), 16'd0);
    check16("R1 pix_rgb", pix_rgb, 16'h0000);
    check16("R1 fifo_ready", 16'(fifo_ready), 16'd1);

    // R2 word before any sof is dropped
    push(32'hFFFFFFFF, 1'b0);
    step();
    check16("R2 no pixel before sof", 16'(pix_valid), 16'd0);

    // R3 pixel enable during the palette load gives nothing
    bpp_sel = 3'd2; order_sel = 1'b0; mono_en = 1'b0; mono8_en = 1'b0;
    for (int w = 0; w < 3; w++) pal_word(w, 4'h0, 3'd2);
    step();
    check16("R3 silent during load", 16'(pix_valid), 16'd0);
    for (int w = 3; w < 8; w++) pal_word(w, 4'h0, 3'd2);
    push(32'h0000000C, 1'b0);
    step();
    check16("R3 ninth word is pixel", pix_rgb, 16'hC806);
    check16("R3 valid after load", 16'(pix_valid), 16'd1);
    repeat (7) step();

    // R10 sweep, hold and underrun
    push(32'h76543210, 1'b0);
    step();
    check16("R10 slot0", pix_rgb, 16'h001F);
    repeat (3) @(negedge clk);
    check16("R10 hold rgb without enable", pix_rgb, 16'h001F);
    check16("R10 hold valid without enable", 16'(pix_valid), 16'd1);
    repeat (7) step();
    check16("R10 slot7", pix_rgb, 16'h7011);
    step();
    check16("R10 underrun valid", 16'(pix_valid), 16'd0);
    check16("R10 underrun rgb held", pix_rgb, 16'h7011);

    // R11 new frame reloads palette
    start_frame(3'd2, 1'b0, 1'b0, 1'b0, 4'hF);
    push(32'h0000000C, 1'b0);
    step();
    check16("R11 new palette used", pix_rgb, 16'h3006);
    repeat (7) step();

    // R12 mode change after sof has no effect
    start_frame(3'd5, 1'b0, 1'b0, 1'b0, 4'h0);
    bpp_sel = 3'd0;
    push(32'hBEEF1234, 1'b0);
    step();
    check16("R12 latched depth", pix_rgb, 16'h1234);
    step();

    // table of vectors
    for (int v = 0; v < 11; v++) begin
      int bits;
      int ppw;
      start_frame(VECS[v].bpp, VECS[v].ord, VECS[v].mono, VECS[v].m8, 4'h0);
      push(VECS[v].word, 1'b0);
      for (int k = 0; k <= int'(VECS[v].slot); k++) step();
      checks++;
      if (pix_rgb !== VECS[v].exp || pix_valid !== 1'b1) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%h/%0b expected=%h/1",
                 VECS[v].req, v, pix_rgb, pix_valid, VECS[v].exp);
      end
      bits = (VECS[v].mono && VECS[v].m8) ? 8 : (VECS[v].bpp <= 3'd3) ? (1 << VECS[v].bpp) : 16;
      ppw  = 32 / bits;
      for (int k = int'(VECS[v].slot) + 1; k < ppw; k++) step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule